// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the device-side command logic of a serial flash. It handles three instructions: arming writes, erasing the whole array, and reading the status byte. It runs on a fast system clock. The serial clock, chip select and data input are registered into that clock domain, and the block finds their edges there. A command frame starts when the select goes low. The block shifts in opcode bits on rising serial-clock edges and judges the frame when the select goes high again.

A whole-array erase starts only when three conditions hold. The frame must end exactly after the eighth opcode bit. The write enable latch must already be armed. Every block-protect bit must be clear. When it starts, the block gives a one-clock request pulse to the abstract array port, which then fills every byte with FFh. It then holds a busy flag for a programmable number of system clocks. The status byte can be read at any time, including during an erase. It is shifted out most significant bit first on the data output.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the write enable latch and the busy flag are 0, `erase_req` is 0 and `do_oe` is 0.
- R2: Opcode 06h framed by exactly 8 bits sets the write enable latch when the controller is idle. The opcode is taken when the select rises.
- R3: Opcodes C7h and 60h each start an erase when framed by exactly 8 bits while the latch is 1, the controller is idle and `blk_prot` is 0. The start is one `erase_req` pulse, one clock wide, that tells the array to set every byte to FFh.
- R4: An erase opcode received while the write enable latch is 0 gives no pulse.
- R5: An erase opcode received while any `blk_prot` bit is 1 gives no pulse and leaves the latch at 1.
- R6: A frame whose select rises after fewer or more than 8 bits is discarded, whatever its opcode: no pulse and no latch change.
- R7: The busy status bit reads 1 from the erase pulse for ERASE_CYCLES system clocks and then returns to 0.
- R8: The write enable latch clears when an erase starts, so it reads 0 while the erase runs and after it.
- R9: While busy, both the write enable opcode and the erase opcodes are ignored.
- R10: After opcode 05h, the status byte appears on `do_o` most significant bit first. Each bit is presented on a serial-clock falling edge, starting with the first falling edge after the eighth opcode bit. The byte repeats with a fresh sample for as long as the select stays low. `do_oe` is 1 from the eighth opcode bit until the select rises. Layout: bit0 = busy, bit1 = write enable latch, bits 5..2 = `blk_prot[3:0]`, bits 7..6 = 0.
- R11: A status read during an erase returns busy = 1.
- R12: An opcode outside 06h, 05h, C7h and 60h has no effect on the latch or on `erase_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| di | input | 1 | Serial data in, sampled on serial-clock rise |
| blk_prot | input | 4 | Block-protect bits; any 1 blocks the erase |
| do_o | output | 1 | Serial data out (status byte) |
| do_oe | output | 1 | Data-out drive enable |
| erase_req | output | 1 | One-clock request to erase the whole array to FFh |

## Verification
The assertions assume that `sclk` and `cs_n` hold each level for at least two system clocks. They also assume that `cs_n` only rises while `sclk` is low, and that `blk_prot` is steady for the length of a frame. The bench keeps to these by holding every serial-clock phase for four system clocks, by raising the select only after the clock has returned low, and by changing the protect bits only between frames. In its random section the bench lets any erase finish before the next frame, so its reference model never has to predict the busy window.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int OPC_W = 8;
    localparam int PROT_W = 4;
    localparam int STAT_W = 8;

    localparam logic [OPC_W-1:0] OPC_ARM     = 8'h06;
    localparam logic [OPC_W-1:0] OPC_STATUS  = 8'h05;
    localparam logic [OPC_W-1:0] OPC_WIPE_A  = 8'hC7;
    localparam logic [OPC_W-1:0] OPC_WIPE_B  = 8'h60;

    typedef struct packed {
        logic wel;
        logic req;
    } ctl_t;

    function automatic logic [STAT_W-1:0] pack_status(input logic [PROT_W-1:0] prot,
                                                      input logic wel,
                                                      input logic busy);
        return {2'b00, prot, wel, busy};
    endfunction
endpackage

// File: rtl/fe_spi_rx.sv
module fe_spi_rx #(
    parameter int CMD_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                di,
    output logic                fall_evt,
    output logic                cs_rise_evt,
    output logic                last_bit_evt,
    output logic                exact_len,
    output logic                selected,
    output logic [CMD_BITS-1:0] cmd,
    output logic [CMD_BITS-1:0] cmd_next
);
    localparam int CW = $clog2(CMD_BITS + 1) + 1;
    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam logic [CW-1:0] CNT_FULL = CW'(CMD_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(CMD_BITS - 1);

    typedef struct packed {
        logic                sclk;
        logic                sclk_prev;
        logic                cs;
        logic                cs_prev;
        logic                di;
        logic [CMD_BITS-1:0] sh;
        logic [CW-1:0]       cnt;
    } rx_t;

    rx_t s_d, s_q;
    logic rise_evt;

    always_comb begin
        rise_evt     = s_q.sclk & ~s_q.sclk_prev & ~s_q.cs;
        fall_evt     = ~s_q.sclk & s_q.sclk_prev & ~s_q.cs;
        cs_rise_evt  = s_q.cs & ~s_q.cs_prev;
        exact_len    = (s_q.cnt == CNT_FULL);
        last_bit_evt = rise_evt && (s_q.cnt == CNT_LAST);
        selected     = ~s_q.cs;
        cmd          = s_q.sh;
        cmd_next     = {s_q.sh[CMD_BITS-2:0], s_q.di};

        s_d           = s_q;
        s_d.sclk      = sclk;
        s_d.sclk_prev = s_q.sclk;
        s_d.cs        = cs_n;
        s_d.cs_prev   = s_q.cs;
        s_d.di        = di;
        if (s_q.cs) begin
            s_d.cnt = '0;
        end else if (rise_evt) begin
            s_d.sh = cmd_next;
            if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sclk: 1'b0, sclk_prev: 1'b0, cs: 1'b1, cs_prev: 1'b1,
                     di: 1'b0, sh: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fe_status_tx.sv
module fe_status_tx #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          fall_evt,
    input  logic          selected,
    input  logic [SW-1:0] status,
    output logic          do_o,
    output logic          do_oe
);
    localparam int IW = $clog2(SW);
    localparam logic [IW-1:0] IDX_TOP = IW'(SW - 1);

    typedef struct packed {
        logic          act;
        logic [IW-1:0] idx;
        logic [SW-1:0] snap;
        logic          bit_o;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!selected) begin
            t_d.act = 1'b0;
            t_d.idx = '0;
        end else if (start) begin
            t_d.act = 1'b1;
            t_d.idx = '0;
        end else if (t_q.act && fall_evt) begin
            if (t_q.idx == '0) begin
                t_d.snap  = status;
                t_d.bit_o = status[SW-1];
            end else begin
                t_d.bit_o = t_q.snap[IDX_TOP - t_q.idx];
            end
            t_d.idx = (t_q.idx == IDX_TOP) ? '0 : t_q.idx + 1'b1;
        end
        do_o  = t_q.bit_o;
        do_oe = t_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (m_q.busy) begin
            if (m_q.cnt == '0) m_d.busy = 1'b0;
            else               m_d.cnt  = m_q.cnt - 1'b1;
        end else if (start) begin
            m_d.busy = 1'b1;
            m_d.cnt  = LOAD;
        end
        busy = m_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import fe_pkg::*;
#(
    parameter int ERASE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              di,
    input  logic [PROT_W-1:0] blk_prot,
    output logic              do_o,
    output logic              do_oe,
    output logic              erase_req
);
    logic              fall_evt, cs_rise_evt, last_bit_evt, exact_len, selected;
    logic [OPC_W-1:0]  cmd, cmd_next;
    logic              wip, wel_q;
    logic              accept, is_wipe, launch, rd_start;
    logic [STAT_W-1:0] status;
    ctl_t              ctl_d, ctl_q;

    fe_spi_rx #(.CMD_BITS(OPC_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .di(di),
        .fall_evt(fall_evt), .cs_rise_evt(cs_rise_evt), .last_bit_evt(last_bit_evt),
        .exact_len(exact_len), .selected(selected), .cmd(cmd), .cmd_next(cmd_next)
    );

    fe_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(launch), .busy(wip)
    );

    fe_status_tx #(.SW(STAT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .fall_evt(fall_evt),
        .selected(selected), .status(status), .do_o(do_o), .do_oe(do_oe)
    );

    always_comb begin
        accept   = cs_rise_evt & exact_len;
        is_wipe  = (cmd == OPC_WIPE_A) || (cmd == OPC_WIPE_B);
        launch   = accept & is_wipe & ctl_q.wel & ~wip & (blk_prot == '0);
        rd_start = last_bit_evt && (cmd_next == OPC_STATUS);
        status   = pack_status(blk_prot, ctl_q.wel, wip);

        ctl_d     = ctl_q;
        ctl_d.req = launch;
        if (launch)
            ctl_d.wel = 1'b0;
        else if (accept && (cmd == OPC_ARM) && !wip)
            ctl_d.wel = 1'b1;

        wel_q     = ctl_q.wel;
        erase_req = ctl_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/fe_chk.sv
module fe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       erase_req,
    input logic       wip,
    input logic       wel,
    input logic [3:0] blk_prot
);
    AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R3

    AST_REQ_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(wel) && !$past(wip) && ($past(blk_prot) == 4'd0))); // R4

    AST_REQ_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (wip && !wel)); // R8

    AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wip) |-> !$rose(wel)); // R9

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(blk_prot) != 4'd0) |-> !erase_req); // R5
endmodule

bind flash_erase_ctl fe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
    .wip(wip), .wel(wel_q), .blk_prot(blk_prot)
);

// File: tb/flash_erase_ctl_test.sv
`timescale 1ns/1ps
module flash_erase_ctl_test;
    localparam int ERASE_CYCLES = 600;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, di = 1'b0;
    logic [3:0] blk_prot = 4'd0;
    logic do_o, do_oe, erase_req;
    int checks = 0, fails = 0, req_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_erase_ctl #(.ERASE_CYCLES(ERASE_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .di(di),
        .blk_prot(blk_prot), .do_o(do_o), .do_oe(do_oe), .erase_req(erase_req)
    );

    always @(negedge clk) if (erase_req) req_cnt++;

    function automatic logic [7:0] exp_status(input logic [3:0] bp, input logic wel, input logic busy);
        return {2'b00, bp, wel, busy};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_cmd(input logic [7:0] op, input int nbits);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            di = (i < 8) ? op[7-i] : 1'($urandom);
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic rd_status(input int nbytes, output logic [7:0] first,
                             output logic [7:0] last, output logic oe_ok);
        logic [7:0] cur;
        cur = '0;
        oe_ok = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0;
            di = 8'h05 >> (7 - i);
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        for (int b = 0; b < nbytes; b++) begin
            for (int k = 0; k < 8; k++) begin
                sclk = 1'b0;
                wait_clk(HALF);
                cur[7-k] = do_o;
                if (do_oe !== 1'b1) oe_ok = 1'b0;
                sclk = 1'b1;
                wait_clk(HALF);
            end
            if (b == 0) first = cur;
        end
        last = cur;
        sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic read_chk(input string req, input logic [7:0] exp);
        logic [7:0] f, l;
        logic ok;
        rd_status(1, f, l, ok);
        chk(req, {24'd0, f}, {24'd0, exp});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] f, l;
        logic ok;
        int base, exp_req, nb, seed;
        logic exp_wel;
        logic [7:0] op;
        logic [3:0] bp;

        seed = $urandom(32'd20240611);
        wait_clk(5);
        chk("R1 erase_req in reset", {31'd0, erase_req}, 32'd0);
        chk("R1 do_oe in reset", {31'd0, do_oe}, 32'd0);
        rst_n = 1'b1;
        wait_clk(3);
        read_chk("R1 status after reset", 8'h00);
        chk("R10 do_oe low after read", {31'd0, do_oe}, 32'd0);

        spi_cmd(8'h06, 8);
        read_chk("R2 arm sets latch", 8'h02);

        base = req_cnt;
        spi_cmd(8'hC7, 8);
        chk("R3 C7h gives one pulse", req_cnt, base + 1);
        read_chk("R11 R8 busy read mid erase", 8'h01);
        spi_cmd(8'h06, 8);
        spi_cmd(8'h60, 8);
        chk("R9 erase while busy ignored", req_cnt, base + 1);
        read_chk("R9 arm while busy ignored", 8'h01);
        wait_clk(ERASE_CYCLES);
        read_chk("R7 busy clears after erase", 8'h00);

        spi_cmd(8'h06, 8);
        base = req_cnt;
        spi_cmd(8'h60, 8);
        chk("R3 60h gives one pulse", req_cnt, base + 1);
        wait_clk(ERASE_CYCLES + 20);
        read_chk("R8 latch clear after erase", 8'h00);

        base = req_cnt;
        spi_cmd(8'hC7, 8);
        chk("R4 no pulse without latch", req_cnt, base);
        read_chk("R4 status unchanged", 8'h00);

        spi_cmd(8'h06, 8);
        blk_prot = 4'b0100;
        spi_cmd(8'hC7, 8);
        chk("R5 protect blocks erase", req_cnt, base);
        read_chk("R5 latch kept and prot shown", exp_status(4'b0100, 1'b1, 1'b0));
        blk_prot = 4'b1001;
        read_chk("R10 prot field position", exp_status(4'b1001, 1'b1, 1'b0));
        blk_prot = 4'd0;

        spi_cmd(8'hC7, 7);
        chk("R6 short frame discarded", req_cnt, base);
        spi_cmd(8'h60, 9);
        chk("R6 long frame discarded", req_cnt, base);
        read_chk("R6 latch unchanged", 8'h02);
        spi_cmd(8'hAA, 8);
        chk("R12 unknown opcode no pulse", req_cnt, base);
        read_chk("R12 latch unchanged", 8'h02);

        spi_cmd(8'hC7, 8);
        chk("R3 launch before arm test", req_cnt, base + 1);
        wait_clk(ERASE_CYCLES + 20);
        spi_cmd(8'h06, 7);
        read_chk("R6 short arm discarded", 8'h00);
        spi_cmd(8'h06, 10);
        read_chk("R6 long arm discarded", 8'h00);

        spi_cmd(8'h06, 8);
        blk_prot = 4'b0010;
        rd_status(2, f, l, ok);
        chk("R10 first byte", {24'd0, f}, {24'd0, exp_status(4'b0010, 1'b1, 1'b0)});
        chk("R10 repeated byte", {24'd0, l}, {24'd0, exp_status(4'b0010, 1'b1, 1'b0)});
        chk("R10 do_oe during read", {31'd0, ok}, 32'd1);

        exp_wel = 1'b1;
        exp_req = req_cnt;
        for (int it = 0; it < 150; it++) begin
            case ($urandom % 5)
                0: op = 8'h06;
                1: op = 8'hC7;
                2: op = 8'h60;
                3: op = 8'h05;
                default: op = 8'($urandom);
            endcase
            if ($urandom % 5 != 0) nb = 8;
            else begin
                nb = 1 + ($urandom % 11);
                if (nb >= 8) nb++;
            end
            bp = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
            blk_prot = bp;
            spi_cmd(op, nb);
            if (nb == 8) begin
                if (op == 8'h06) exp_wel = 1'b1;
                else if ((op == 8'hC7 || op == 8'h60) && exp_wel && bp == 4'd0) begin
                    exp_req++;
                    exp_wel = 1'b0;
                    wait_clk(ERASE_CYCLES + 20);
                end
            end
            chk("R6 R3 random pulse count", req_cnt, exp_req);
            read_chk("R2 R5 random status", exp_status(bp, exp_wel, 1'b0));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule